// File: doc/BRIEF.md
# Pin Edge Interrupt and Wake Detector

This block watches a bank of already-synchronized pin levels and reports edges on them. Each cycle it compares every pin with its level from the cycle before, which gives a rising-edge vector and a falling-edge vector. Two per-pin mask registers select which rising and which falling edges count as interrupts. An edge that passes these masks sets that pin's bit in a sticky status word. The status word stays set until software writes a one to the matching bit of a clear register. The interrupt request is high whenever any status bit is set. The block also reports the index of the lowest pending pin, so a handler can take several pending pins one after another, lowest first.

A second, independent pair of rising and falling masks drives the wakeup path. An edge on a pin enabled there produces a one-cycle pulse on the wake output. That pulse does not touch the status word. The block detects edges only; it has no level-sensitive mode. All masks come out of reset disabled, so no pin reports anything until software enables it.

Software reaches the block over a small register bus. A write takes effect at the clock edge on which the write strobe is high. Read data is combinational from the address.

Top module: `pin_edge_notifier`

## Requirements
- R1: After reset, every register reads 0, and both irq_o and wake_o are low.
- R2: A 0-to-1 change on a pin whose bit is set in the rising interrupt mask (address 0) sets that pin's status bit. The bit is visible one clock edge after the new level is presented.
- R3: A 1-to-0 change on a pin whose bit is set in the falling interrupt mask (address 1) sets that pin's status bit. A pin with both masks set reports both kinds of change.
- R4: An edge whose direction is not enabled in the interrupt masks leaves the status word and irq_o unchanged.
- R5: wake_o pulses high for exactly one cycle after an edge whose direction is enabled for that pin in the rising wake mask (address 2) or the falling wake mask (address 3). The wake masks have no effect on the status word, and the interrupt masks have no effect on wake_o.
- R6: Writing the clear register (address 5) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When an enabled edge and a clear for the same bit fall in the same cycle, the bit stays set.
- R8: irq_o is high exactly when at least one status bit is set.
- R9: first_pend_o gives the index of the lowest set status bit, and 0 when none is set.
- R10: The register map is as follows. Addresses 0 to 3 are read/write masks. Address 4 is the status word; it is read-only, and writes to it are ignored. Address 5 is write-only and reads 0. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl_i | input | N_PINS | Synchronized pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request, OR of the status bits |
| wake_o | output | 1 | One-cycle wakeup request |
| first_pend_o | output | IDX_W | Index of the lowest pending status bit |

## Verification
The assertions assume the pin levels come from a synchronizer, so each value is stable for a whole clock cycle. They also assume reset is held long enough for the history register to capture a real pin level before edges are judged. The bench drives pins and bus fields only at the falling clock edge and holds reset for several cycles. Every change it makes is therefore a clean single-cycle step, and none overlaps reset release.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;
  localparam int ADDR_W = 3;

  // register selector; offsets 0..3 also index the mask array
  typedef enum logic [ADDR_W-1:0] {
    REG_RISE_IRQ  = 3'd0,
    REG_FALL_IRQ  = 3'd1,
    REG_RISE_WAKE = 3'd2,
    REG_FALL_WAKE = 3'd3,
    REG_STATUS    = 3'd4,
    REG_CLEAR     = 3'd5
  } reg_sel_e;

  localparam int N_MASKS = 4;
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic [N_PINS-1:0] lvl_i,
  output logic [N_PINS-1:0] rise_o,
  output logic [N_PINS-1:0] fall_o
);
  logic [N_PINS-1:0] prev_q;

  function automatic logic [N_PINS-1:0] went_up(input logic [N_PINS-1:0] now_v,
                                                input logic [N_PINS-1:0] old_v);
    return now_v & ~old_v;
  endfunction

  function automatic logic [N_PINS-1:0] went_down(input logic [N_PINS-1:0] now_v,
                                                  input logic [N_PINS-1:0] old_v);
    return ~now_v & old_v;
  endfunction

  // history needs no reset: it tracks the pins during reset as well
  always_ff @(posedge clk) begin
    prev_q <= lvl_i;
  end

  assign rise_o = went_up(lvl_i, prev_q);
  assign fall_o = went_down(lvl_i, prev_q);
endmodule

// File: rtl/edge_mask_regs.sv
module edge_mask_regs
  import pin_edge_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rise_irq_o,
  output logic [N_PINS-1:0] fall_irq_o,
  output logic [N_PINS-1:0] rise_wake_o,
  output logic [N_PINS-1:0] fall_wake_o,
  output logic [N_PINS-1:0] clear_o
);
  logic [N_MASKS-1:0][N_PINS-1:0] mask_q;

  for (genvar k = 0; k < N_MASKS; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[k] <= '0;
      else if (wr_i && addr_i == ADDR_W'(k))
        mask_q[k] <= wdata_i;
    end
  end

  assign rise_irq_o  = mask_q[REG_RISE_IRQ];
  assign fall_irq_o  = mask_q[REG_FALL_IRQ];
  assign rise_wake_o = mask_q[REG_RISE_WAKE];
  assign fall_wake_o = mask_q[REG_FALL_WAKE];
  assign clear_o     = (wr_i && addr_i == REG_CLEAR) ? wdata_i : '0;
endmodule

// File: rtl/edge_status.sv
module edge_status #(
  parameter int N_PINS = 32,
  parameter int IDX_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] hits_i,
  input  logic [N_PINS-1:0] clear_i,
  output logic [N_PINS-1:0] status_o,
  output logic [IDX_W-1:0]  first_o,
  output logic              any_o
);
  logic [N_PINS-1:0] status_q;

  // clear first, then set: a same-cycle edge keeps its bit
  function automatic logic [N_PINS-1:0] next_status(input logic [N_PINS-1:0] cur,
                                                    input logic [N_PINS-1:0] clr,
                                                    input logic [N_PINS-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_index(input logic [N_PINS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      status_q <= '0;
    else
      status_q <= next_status(status_q, clear_i, hits_i);
  end

  assign status_o = status_q;
  assign first_o  = lowest_index(status_q);
  assign any_o    = |status_q;
endmodule

// File: rtl/pin_edge_notifier.sv
module pin_edge_notifier
  import pin_edge_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int IDX_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_lvl_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic [IDX_W-1:0]  first_pend_o
);
  // named internal events, visible to the bound checker
  logic [N_PINS-1:0] rise_ev, fall_ev;
  logic [N_PINS-1:0] rise_irq_m, fall_irq_m, rise_wake_m, fall_wake_m;
  logic [N_PINS-1:0] clear_vec;
  logic [N_PINS-1:0] irq_hits, wake_hits;
  logic [N_PINS-1:0] status_vec;
  logic              wake_q;

  function automatic logic [N_PINS-1:0] masked_edges(input logic [N_PINS-1:0] up,
                                                     input logic [N_PINS-1:0] dn,
                                                     input logic [N_PINS-1:0] up_en,
                                                     input logic [N_PINS-1:0] dn_en);
    return (up & up_en) | (dn & dn_en);
  endfunction

  edge_sense #(.N_PINS(N_PINS)) u_sense (
    .clk    (clk),
    .lvl_i  (pin_lvl_i),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  edge_mask_regs #(.N_PINS(N_PINS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rise_irq_o  (rise_irq_m),
    .fall_irq_o  (fall_irq_m),
    .rise_wake_o (rise_wake_m),
    .fall_wake_o (fall_wake_m),
    .clear_o     (clear_vec)
  );

  assign irq_hits  = masked_edges(rise_ev, fall_ev, rise_irq_m, fall_irq_m);
  assign wake_hits = masked_edges(rise_ev, fall_ev, rise_wake_m, fall_wake_m);

  edge_status #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits_i   (irq_hits),
    .clear_i  (clear_vec),
    .status_o (status_vec),
    .first_o  (first_pend_o),
    .any_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      wake_q <= 1'b0;
    else
      wake_q <= |wake_hits;
  end
  assign wake_o = wake_q;

  always_comb begin
    case (bus_addr_i)
      REG_RISE_IRQ:  bus_rdata_o = rise_irq_m;
      REG_FALL_IRQ:  bus_rdata_o = fall_irq_m;
      REG_RISE_WAKE: bus_rdata_o = rise_wake_m;
      REG_FALL_WAKE: bus_rdata_o = fall_wake_m;
      REG_STATUS:    bus_rdata_o = status_vec;
      default:       bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pin_edge_notifier_chk.sv
module pin_edge_notifier_chk #(
  parameter int N_PINS = 32,
  parameter int IDX_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] irq_hits,
  input logic [N_PINS-1:0] wake_hits,
  input logic [N_PINS-1:0] clear_vec,
  input logic [N_PINS-1:0] status_vec,
  input logic              irq_o,
  input logic              wake_o,
  input logic [IDX_W-1:0]  first_pend_o
);
  logic [N_PINS-1:0] below_first;
  always_comb begin
    for (int i = 0; i < N_PINS; i++) below_first[i] = (i < int'(first_pend_o));
  end

  // R2/R3: a set status bit survives unless a clear hit it
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status_vec) & ~$past(clear_vec)) & ~status_vec) == '0));

  // R4: a newly set bit must come from an enabled edge
  p_set_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((status_vec & ~$past(status_vec)) & ~$past(irq_hits)) == '0));

  // R7 with R6: a cleared bit without a competing edge is low afterwards
  p_clear_or_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((($past(clear_vec) & ~$past(irq_hits))) & status_vec) == '0));

  // R7: an edge always leaves its bit set, clear or not
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(irq_hits)) & ~status_vec) == '0));

  // R8: the request rises only because an enabled edge arrived
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(irq_hits) != '0));

  // R5: wake pulse only after a wake-enabled edge
  p_wake_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(wake_hits) != '0));

  // R9: reported index is set and nothing below it is
  p_first_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_vec[first_pend_o] && ((status_vec & below_first) == '0)));
endmodule

bind pin_edge_notifier pin_edge_notifier_chk #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_hits     (irq_hits),
  .wake_hits    (wake_hits),
  .clear_vec    (clear_vec),
  .status_vec   (status_vec),
  .irq_o        (irq_o),
  .wake_o       (wake_o),
  .first_pend_o (first_pend_o)
);

// File: tb/pin_edge_notifier_test.sv
module pin_edge_notifier_test;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         wr = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq, wake;
  logic [IW-1:0] first;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_edge_notifier #(.N_PINS(N), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl_i(pins), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake), .first_pend_o(first)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [N-1:0] exp);
    addr = a;
    #1;
    check(tag, 32'(rdata), 32'(exp));
  endtask

  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    int k;
    k = 0;
    while (k < N && !v[k]) k++;
    return (k == N) ? '0 : IW'(k);
  endfunction

  // status, request line and lowest index against one expected word
  task automatic check_status(input string tag, input logic [N-1:0] exp);
    rd_check({tag, " status"}, 3'd4, exp);
    check({"R8 irq ", tag}, 32'(irq), 32'(exp != '0));
    check({"R9 first ", tag}, 32'(first), 32'(lowest(exp)));
  endtask

  initial begin
    @(negedge clk);
    repeat (4) step();
    rst_n = 1'b1;
    step();

    // R1 reset state, R10 whole map
    for (int a = 0; a < 8; a++) rd_check("R1 reset read", 3'(a), '0);
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 wake after reset", 32'(wake), 0);

    // R10: mask readback, status write ignored, clear and spare addresses read 0
    for (int a = 0; a < 4; a++) begin
      wr_reg(3'(a), 8'hA5 ^ 8'(a * 17));
      rd_check("R10 mask readback", 3'(a), 8'hA5 ^ 8'(a * 17));
      wr_reg(3'(a), '0);
    end
    wr_reg(3'd4, ALL);
    rd_check("R10 status write ignored", 3'd4, '0);
    rd_check("R10 clear reads zero", 3'd5, '0);
    rd_check("R10 addr6 zero", 3'd6, '0);
    rd_check("R10 addr7 zero", 3'd7, '0);

    // R2 R3 R4: every pin under every interrupt-mask combination
    for (int p = 0; p < N; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [N-1:0] b;
        b = N'(1) << p;
        wr_reg(3'd0, cfg[0] ? b : '0);
        wr_reg(3'd1, cfg[1] ? b : '0);
        pins = pins | b;
        step();
        check_status(cfg[0] ? "R2 rise" : "R4 rise masked", cfg[0] ? b : '0);
        check("R5 no wake from irq masks", 32'(wake), 0);
        wr_reg(3'd5, ALL);
        check_status("R6 clear all", '0);
        pins = pins & ~b;
        step();
        check_status(cfg[1] ? "R3 fall" : "R4 fall masked", cfg[1] ? b : '0);
        wr_reg(3'd5, ALL);
      end
    end
    wr_reg(3'd0, '0);
    wr_reg(3'd1, '0);

    // R5: wake masks, one-cycle pulse, status untouched
    for (int p = 0; p < N; p += 3) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic [N-1:0] b;
        b = N'(1) << p;
        wr_reg(3'd2, cfg[0] ? b : '0);
        wr_reg(3'd3, cfg[1] ? b : '0);
        pins = pins | b;
        step();
        check("R5 wake on rise", 32'(wake), 32'(cfg[0]));
        rd_check("R5 wake leaves status", 3'd4, '0);
        step();
        check("R5 wake pulse ends", 32'(wake), 0);
        pins = pins & ~b;
        step();
        check("R5 wake on fall", 32'(wake), 32'(cfg[1]));
        step();
        check("R5 wake pulse ends", 32'(wake), 0);
      end
    end
    wr_reg(3'd2, '0);
    wr_reg(3'd3, '0);

    // R6 R9: several pending bits, partial clears
    wr_reg(3'd0, ALL);
    for (int t = 0; t < 6; t++) begin
      logic [N-1:0] pat, clr;
      pat = 8'h96 ^ 8'(t * 37);
      clr = 8'h3C << (t % 3);
      pins = pat;
      step();
      check_status("R9 multi pending", pat);
      wr_reg(3'd5, clr);
      check_status("R6 partial clear", pat & ~clr);
      wr_reg(3'd5, '0);
      check_status("R6 zero write no effect", pat & ~clr);
      wr_reg(3'd5, ALL);
      pins = '0;
      step();
    end

    // R7: edge and clear on the same bit in the same cycle
    wr_reg(3'd5, ALL);
    pins = 8'h10;
    step();
    check_status("R7 setup", 8'h10);
    pins = 8'h00;
    step();
    pins = 8'h10;
    wr = 1'b1; addr = 3'd5; wdata = 8'h10;
    step();
    wr = 1'b0; wdata = '0;
    check_status("R7 edge beats clear", 8'h10);
    wr_reg(3'd5, 8'h10);
    check_status("R7 later clear", '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule